// File: doc/BRIEF.md
# VGA Sequencer and Graphics Register File

This block holds the two indexed register banks of a VGA-compatible adapter, the sequencer bank and the graphics-controller bank. The host reaches them through a byte-wide I/O port space. Each bank uses two ports. The even port selects the index, and the next port reads or writes the register at that index. The block clears reserved bits on every data write. It forces the unlock register of the sequencer to one of two legal values. It answers reads locally, and it raises a miss flag when a data read targets an index that the block does not hold.

A request can be 1, 2, 4 or 8 bytes wide. The block splits it into byte operations on ascending port addresses, one per clock. Byte lane k of the request goes to, or comes from, address `base + k`. A single wide write can therefore load an index and then its data in order. The current contents of both banks are driven out as flat buses for the video-memory read and write datapaths.

From two of the stored registers, the block decodes a "standard planar mode" flag. When that flag rises, the block emits a one-cycle start pulse and sets a sticky cache-enable bit.

Top module: `vga_seqgfx_regs`

## Requirements
- R1: A byte write to port 0x3C4 (sequencer) or 0x3CE (graphics) stores the full 8-bit value as that bank's index. Sequencer values of 8 or more are accepted. A byte read of the same port returns the stored index.
- R2: A byte write to port 0x3C5 stores data into the sequencer register at the current index, keeping only these bits: index 0 mask 0x03, index 1 mask 0x3D, index 2 mask 0x0F, index 3 mask 0x3F, index 4 mask 0x0E, index 5 mask 0x00, index 7 mask 0xFF.
- R3: A write to sequencer index 6 stores 0x12 when (value AND 0x17) equals 0x12, and stores 0x0F otherwise.
- R4: A byte write to port 0x3CF stores data into the graphics register at the current index, keeping these bits: indices 0, 1, 2, 6 and 7 mask 0x0F, index 3 mask 0x1F, index 4 mask 0x03, index 5 mask 0x7B, index 8 mask 0xFF.
- R5: A data-port read returns the register stored at the current index. A read lane at any address other than the four ports returns 0x00, and a write there has no effect.
- R6: A data read with sequencer index of 8 or more, or with graphics index of 9 or more, returns 0x00 in that lane and sets `rsp_miss` with the response. A data write at such an index changes nothing.
- R7: `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Lane k (bits 8k+7..8k) goes to address `req_addr + k`, in ascending order, one byte per clock. The first byte is done at the accepting edge, and `busy` stays high until the last byte. `rsp_valid`, `rsp_rdata` and `rsp_miss` are valid for one cycle after the last byte of a read.
- R8: `req_valid` is ignored while `busy` is high.
- R9: `std_mode` is high exactly when sequencer register 7 equals 0x00 and graphics register 6 equals 0x05.
- R10: `cache_start` is high for the one cycle in which `std_mode` has just risen. `cache_en` is set from the next cycle on and stays set when `std_mode` falls. Every later rise pulses `cache_start` again.
- R11: A synchronous reset clears both indices, all registers, `cache_en` and any access in progress. `seq_regs` carries sequencer register i at bits 8i+7..8i, and `gfx_regs` carries graphics register i at bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O port address of byte lane 0 |
| req_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_wdata | input | 64 | Write data, lane k at bits 8k+7..8k |
| busy | output | 1 | Multi-byte access in progress |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_rdata | output | 64 | Read data, lane k at bits 8k+7..8k |
| rsp_miss | output | 1 | At least one lane hit an uncached data index |
| seq_regs | output | 64 | Sequencer registers 0..7, flattened |
| gfx_regs | output | 72 | Graphics registers 0..8, flattened |
| std_mode | output | 1 | Standard planar mode decoded |
| cache_start | output | 1 | One-cycle pulse on entry to standard mode |
| cache_en | output | 1 | Sticky cache-enable bit |

## Verification
The embedded properties assume that reset is held across at least one clock edge before any request. They also assume that every request input is at a known level at each edge where `busy` is low. No assumption is made about what a requester does while `busy` is high, because those cycles are exactly where requests must be dropped.

The stimulus changes inputs only on the falling clock edge. It holds `req_valid` for a single accepting edge, except in one deliberate case where a second request is held throughout a busy window. It uses all four width codes and addresses that straddle both port pairs. This makes the lane, miss and mode properties fire on real transitions rather than hold vacuously.

// File: rtl/vgar_pkg.sv
package vgar_pkg;

    localparam int PORT_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * BYTE_W;
    localparam int LANE_W    = $clog2(MAX_BYTES);

    localparam int SEQ_NREG  = 8;
    localparam int GFX_NREG  = 9;

    localparam logic [PORT_W-1:0] SEQ_IDX_PORT = 16'h03C4;
    localparam logic [PORT_W-1:0] GFX_IDX_PORT = 16'h03CE;

    localparam int SEQ_UNLOCK_IDX = 6;
    localparam int SEQ_MODE_IDX   = 7;
    localparam int GFX_MAP_IDX    = 6;
    localparam logic [BYTE_W-1:0] GFX_MAP_STD = 8'h05;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } acc_size_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_RUN  = 1'b1
    } split_fsm_e;

    typedef struct packed {
        logic                valid;
        logic                wr;
        logic [PORT_W-1:0]   addr;
        logic [BYTE_W-1:0]   data;
    } byte_op_t;

    function automatic logic [BYTE_W-1:0] seq_keep(input int unsigned g);
        case (g)
            0:       return 8'h03;
            1:       return 8'h3D;
            2:       return 8'h0F;
            3:       return 8'h3F;
            4:       return 8'h0E;
            5:       return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] gfx_keep(input int unsigned g);
        case (g)
            0, 1, 2, 6, 7: return 8'h0F;
            3:             return 8'h1F;
            4:             return 8'h03;
            5:             return 8'h7B;
            default:       return 8'hFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] unlock_coerce(input logic [BYTE_W-1:0] v);
        return ((v & 8'h17) == 8'h12) ? 8'h12 : 8'h0F;
    endfunction

    function automatic logic [LANE_W-1:0] final_lane(input acc_size_e s);
        case (s)
            SZ_1:    return 3'd0;
            SZ_2:    return 3'd1;
            SZ_4:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/vgar_bank.sv
module vgar_bank
    import vgar_pkg::*;
#(
    parameter bit                IS_SEQ   = 1'b1,
    parameter int                NREG     = SEQ_NREG,
    parameter logic [PORT_W-1:0] IDX_PORT = SEQ_IDX_PORT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  byte_op_t                 op,
    output logic [BYTE_W-1:0]        rd_byte,
    output logic                     rd_miss,
    output logic [NREG*BYTE_W-1:0]   regs_flat
);

    localparam logic [PORT_W-1:0] DAT_PORT = IDX_PORT + 16'd1;

    logic [BYTE_W-1:0] idx_q;
    logic              sel_idx;
    logic              sel_dat;
    logic              idx_held;
    logic [BYTE_W-1:0] dat_val;

    assign sel_idx  = op.valid && (op.addr == IDX_PORT);
    assign sel_dat  = op.valid && (op.addr == DAT_PORT);
    assign idx_held = (idx_q < BYTE_W'(NREG));

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (sel_idx && op.wr)
            idx_q <= op.data;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [BYTE_W-1:0] KEEP   = IS_SEQ ? seq_keep(g) : gfx_keep(g);
            localparam bit                COERCE = IS_SEQ && (g == SEQ_UNLOCK_IDX);

            logic [BYTE_W-1:0] r_q;
            logic [BYTE_W-1:0] wval;

            if (COERCE) begin : g_coerce
                assign wval = unlock_coerce(op.data);
            end else begin : g_mask
                assign wval = op.data & KEEP;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= '0;
                else if (sel_dat && op.wr && (idx_q == BYTE_W'(g)))
                    r_q <= wval;
            end

            assign regs_flat[g*BYTE_W +: BYTE_W] = r_q;

            if (COERCE) begin : g_chk_unlock
                assert_unlock_two_values_R3: assert property (@(posedge clk) disable iff (rst)
                    (r_q == 8'h00) || (r_q == 8'h0F) || (r_q == 8'h12));
            end else if (IS_SEQ) begin : g_chk_seq
                assert_seq_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
                    (r_q & ~KEEP) == 8'h00);
            end else begin : g_chk_gfx
                assert_gfx_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
                    (r_q & ~KEEP) == 8'h00);
            end
        end
    endgenerate

    always_comb begin
        dat_val = '0;
        for (int g = 0; g < NREG; g++) begin
            if (idx_q == BYTE_W'(g))
                dat_val = regs_flat[g*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        if (sel_idx)
            rd_byte = idx_q;
        else if (sel_dat && idx_held)
            rd_byte = dat_val;
        else
            rd_byte = '0;
    end

    assign rd_miss = sel_dat && !op.wr && !idx_held;

    assert_index_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_idx && op.wr) |=> (idx_q == $past(op.data)));

    assert_uncached_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_dat && op.wr && !idx_held) |=> $stable(regs_flat));

endmodule

// File: rtl/vgar_splitter.sv
module vgar_splitter
    import vgar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [PORT_W-1:0]    req_addr,
    input  acc_size_e            req_size,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BYTE_W-1:0]    lane_rd,
    input  logic                 lane_miss,
    output byte_op_t             op,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_miss
);

    split_fsm_e        state_q;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] final_q;
    logic [PORT_W-1:0] base_q;
    logic [DATA_W-1:0] wbuf_q;
    logic              wr_q;
    logic [DATA_W-1:0] acc_q;
    logic              miss_q;
    logic              rsp_q;
    logic              idle;
    logic              last;

    assign idle = (state_q == FSM_IDLE);
    assign busy = !idle;

    always_comb begin
        op.valid = (idle && req_valid) || !idle;
        op.wr    = idle ? req_write : wr_q;
        op.addr  = idle ? req_addr : (base_q + PORT_W'(lane_q));
        op.data  = idle ? req_wdata[BYTE_W-1:0] : wbuf_q[{lane_q, 3'b000} +: BYTE_W];
        last     = idle ? (final_lane(req_size) == '0) : (lane_q == final_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FSM_IDLE;
            lane_q  <= '0;
            final_q <= '0;
            base_q  <= '0;
            wbuf_q  <= '0;
            wr_q    <= 1'b0;
            acc_q   <= '0;
            miss_q  <= 1'b0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (op.valid) begin
                if (idle) begin
                    base_q  <= req_addr;
                    wbuf_q  <= req_wdata;
                    wr_q    <= req_write;
                    final_q <= final_lane(req_size);
                    acc_q   <= DATA_W'(lane_rd);
                    miss_q  <= lane_miss;
                end else begin
                    acc_q[{lane_q, 3'b000} +: BYTE_W] <= lane_rd;
                    miss_q <= miss_q | lane_miss;
                end
                if (last) begin
                    state_q <= FSM_IDLE;
                    lane_q  <= '0;
                    rsp_q   <= !op.wr;
                end else begin
                    state_q <= FSM_RUN;
                    lane_q  <= idle ? LANE_W'(1) : lane_q + LANE_W'(1);
                end
            end
        end
    end

    assign rsp_valid = rsp_q;
    assign rsp_rdata = acc_q;
    assign rsp_miss  = rsp_q & miss_q;

    assert_lane_within_access_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lane_q != '0) && (lane_q <= final_q));

    assert_no_response_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    assert_busy_holds_request_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy && $stable(base_q) && $stable(wbuf_q) && $stable(wr_q));

endmodule

// File: rtl/vgar_mode.sv
module vgar_mode
    import vgar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] seq_mode_reg,
    input  logic [BYTE_W-1:0] gfx_map_reg,
    output logic              std_mode,
    output logic              cache_start,
    output logic              cache_en
);

    logic std_prev_q;
    logic cache_q;

    assign std_mode    = (seq_mode_reg == 8'h00) && (gfx_map_reg == GFX_MAP_STD);
    assign cache_start = std_mode && !std_prev_q;
    assign cache_en    = cache_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            std_prev_q <= 1'b0;
            cache_q    <= 1'b0;
        end else begin
            std_prev_q <= std_mode;
            if (cache_start)
                cache_q <= 1'b1;
        end
    end

    assert_start_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        cache_start |=> !cache_start);

    assert_cache_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cache_en |=> cache_en);

    assert_start_sets_cache_R10: assert property (@(posedge clk) disable iff (rst)
        cache_start |=> cache_en);

endmodule

// File: rtl/vga_seqgfx_regs.sv
module vga_seqgfx_regs
    import vgar_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [PORT_W-1:0]          req_addr,
    input  logic [1:0]                 req_size,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       busy,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       rsp_miss,
    output logic [SEQ_NREG*BYTE_W-1:0] seq_regs,
    output logic [GFX_NREG*BYTE_W-1:0] gfx_regs,
    output logic                       std_mode,
    output logic                       cache_start,
    output logic                       cache_en
);

    byte_op_t          op;
    logic [BYTE_W-1:0] seq_rd;
    logic [BYTE_W-1:0] gfx_rd;
    logic              seq_miss;
    logic              gfx_miss;

    vgar_splitter u_split (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (acc_size_e'(req_size)),
        .req_wdata (req_wdata),
        .lane_rd   (seq_rd | gfx_rd),
        .lane_miss (seq_miss | gfx_miss),
        .op        (op),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_miss  (rsp_miss)
    );

    vgar_bank #(
        .IS_SEQ   (1'b1),
        .NREG     (SEQ_NREG),
        .IDX_PORT (SEQ_IDX_PORT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .rd_byte   (seq_rd),
        .rd_miss   (seq_miss),
        .regs_flat (seq_regs)
    );

    vgar_bank #(
        .IS_SEQ   (1'b0),
        .NREG     (GFX_NREG),
        .IDX_PORT (GFX_IDX_PORT)
    ) u_gfx (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .rd_byte   (gfx_rd),
        .rd_miss   (gfx_miss),
        .regs_flat (gfx_regs)
    );

    vgar_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .seq_mode_reg (seq_regs[SEQ_MODE_IDX*BYTE_W +: BYTE_W]),
        .gfx_map_reg  (gfx_regs[GFX_MAP_IDX*BYTE_W +: BYTE_W]),
        .std_mode     (std_mode),
        .cache_start  (cache_start),
        .cache_en     (cache_en)
    );

    assert_miss_only_with_response_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> rsp_valid && !busy);

    assert_banks_never_both_drive_R5: assert property (@(posedge clk) disable iff (rst)
        !((seq_rd != '0) && (gfx_rd != '0)));

endmodule

// File: tb/vga_seqgfx_regs_bench.sv
`timescale 1ns/1ps
module vga_seqgfx_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        busy;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_miss;
    logic [63:0] seq_regs;
    logic [71:0] gfx_regs;
    logic        std_mode;
    logic        cache_start;
    logic        cache_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vga_seqgfx_regs u_vga_seqgfx_regs (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata),
        .busy (busy), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_miss (rsp_miss),
        .seq_regs (seq_regs), .gfx_regs (gfx_regs),
        .std_mode (std_mode), .cache_start (cache_start), .cache_en (cache_en)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  sz;
        logic [63:0] data;
        logic [63:0] exp;
        logic        exp_miss;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h03C4, 2'd0, 64'h02,       64'h0, 1'b0, 8'd1},  // R1 seq index 2
        '{1'b1, 16'h03C5, 2'd0, 64'hFF,       64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h0F, 1'b0, 8'd2}, // R2 idx2
        '{1'b0, 16'h03C4, 2'd0, 64'h0,        64'h02, 1'b0, 8'd1}, // R1 readback
        '{1'b1, 16'h03C4, 2'd1, 64'hFF00,     64'h0, 1'b0, 8'd7},  // R7 idx then data
        '{1'b0, 16'h03C4, 2'd1, 64'h0,        64'h0300, 1'b0, 8'd7},
        '{1'b1, 16'h03C4, 2'd1, 64'hAB01,     64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h29, 1'b0, 8'd2}, // R2 idx1
        '{1'b1, 16'h03C4, 2'd1, 64'hFF03,     64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h3F, 1'b0, 8'd2},
        '{1'b1, 16'h03C4, 2'd1, 64'h7704,     64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h06, 1'b0, 8'd2},
        '{1'b1, 16'h03C4, 2'd1, 64'hFF05,     64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h00, 1'b0, 8'd2},
        '{1'b1, 16'h03C4, 2'd1, 64'hC307,     64'h0, 1'b0, 8'd2},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'hC3, 1'b0, 8'd2},
        '{1'b1, 16'h03C4, 2'd1, 64'h5A06,     64'h0, 1'b0, 8'd3},  // R3 coerce to 0x12
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h12, 1'b0, 8'd3},
        '{1'b1, 16'h03C4, 2'd1, 64'h1306,     64'h0, 1'b0, 8'd3},  // R3 coerce to 0x0F
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h0F, 1'b0, 8'd3},
        '{1'b1, 16'h03C4, 2'd1, 64'h4408,     64'h0, 1'b0, 8'd6},  // R6 uncached write
        '{1'b0, 16'h03C4, 2'd0, 64'h0,        64'h08, 1'b0, 8'd1},
        '{1'b0, 16'h03C5, 2'd0, 64'h0,        64'h00, 1'b1, 8'd6}, // R6 miss seq
        '{1'b1, 16'h03CE, 2'd1, 64'hFF05,     64'h0, 1'b0, 8'd4},  // R4
        '{1'b0, 16'h03CF, 2'd0, 64'h0,        64'h7B, 1'b0, 8'd4},
        '{1'b1, 16'h03CE, 2'd1, 64'hFF03,     64'h0, 1'b0, 8'd4},
        '{1'b0, 16'h03CF, 2'd0, 64'h0,        64'h1F, 1'b0, 8'd4},
        '{1'b1, 16'h03CE, 2'd1, 64'hFF04,     64'h0, 1'b0, 8'd4},
        '{1'b0, 16'h03CF, 2'd0, 64'h0,        64'h03, 1'b0, 8'd4},
        '{1'b1, 16'h03CE, 2'd1, 64'hFF08,     64'h0, 1'b0, 8'd4},
        '{1'b0, 16'h03CE, 2'd1, 64'h0,        64'hFF08, 1'b0, 8'd4},
        '{1'b1, 16'h03CE, 2'd1, 64'hFF07,     64'h0, 1'b0, 8'd4},
        '{1'b0, 16'h03CF, 2'd0, 64'h0,        64'h0F, 1'b0, 8'd4},
        '{1'b1, 16'h03CE, 2'd1, 64'hFF00,     64'h0, 1'b0, 8'd4},
        '{1'b0, 16'h03CA, 2'd3, 64'h0,        64'h0000_0F00_0000_0000, 1'b0, 8'd7}, // R7 8-byte
        '{1'b1, 16'h03CE, 2'd0, 64'h09,       64'h0, 1'b0, 8'd6},
        '{1'b0, 16'h03CF, 2'd0, 64'h0,        64'h00, 1'b1, 8'd6}, // R6 miss gfx
        '{1'b0, 16'h03C2, 2'd2, 64'h0,        64'h0008_0000, 1'b1, 8'd6},
        '{1'b1, 16'h03C4, 2'd2, 64'hEEDD_3D01, 64'h0, 1'b0, 8'd5}, // R5 stray lanes
        '{1'b0, 16'h03C4, 2'd1, 64'h0,        64'h3D01, 1'b0, 8'd7},
        '{1'b0, 16'h03C0, 2'd0, 64'h0,        64'h00, 1'b0, 8'd5}  // R5 non-port read
    };

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                          input logic [63:0] d, output logic [63:0] rd,
                          output logic miss, output logic got);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        got  = rsp_valid;
        rd   = rsp_rdata;
        miss = rsp_miss;
    endtask

    initial begin
        logic [63:0] rd;
        logic        miss;
        logic        got;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11", {8'h0, seq_regs}, 72'h0, "seq_regs after reset");
        check("R11", gfx_regs, 72'h0, "gfx_regs after reset");
        check("R11", {busy, rsp_valid, cache_en}, 72'h0, "busy/rsp/cache after reset");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].data, rd, miss, got);
            if (!VECS[i].wr) begin
                string tg;
                tg = $sformatf("R%0d", VECS[i].req);
                check(tg, {63'h0, got}, 72'h1, $sformatf("vec %0d rsp_valid", i));
                check(tg, rd, VECS[i].exp, $sformatf("vec %0d rdata", i));
                check(tg, miss, VECS[i].exp_miss, $sformatf("vec %0d miss", i));
            end else begin
                check("R7", {rsp_valid, busy}, 72'h0, $sformatf("vec %0d write idle", i));
            end
        end

        // R9 mode off while seq7 = 0xC3 even when gfx6 becomes 0x05 (mask 0x0F on 0xF5)
        check("R9", std_mode, 1'b0, "std_mode before map");
        access(1'b1, 16'h03CE, 2'd1, 64'hF506, rd, miss, got);
        check("R4", gfx_regs[6*8 +: 8], 8'h05, "gfx6 masked");
        check("R9", std_mode, 1'b0, "std_mode with seq7 nonzero");
        check("R10", cache_en, 1'b0, "cache_en before entry");

        // R10 entry: seq7 <- 0
        access(1'b1, 16'h03C4, 2'd1, 64'h0007, rd, miss, got);
        check("R9", std_mode, 1'b1, "std_mode entered");
        check("R10", {cache_start, cache_en}, 72'h2, "start pulse, cache not yet");
        @(negedge clk);
        check("R10", {cache_start, cache_en}, 72'h1, "pulse ended, cache set");

        // leave mode: cache_en stays
        access(1'b1, 16'h03C4, 2'd1, 64'h0107, rd, miss, got);
        check("R9", std_mode, 1'b0, "std_mode left");
        check("R10", cache_en, 1'b1, "cache_en sticky");
        check("R11", seq_regs[7*8 +: 8], 8'h01, "seq_regs lane 7");

        // R8 request during busy dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h03C0; req_size = 2'd2;
        req_wdata = 64'h1122_3344;
        @(posedge clk);
        @(negedge clk);
        req_addr = 16'h03C4; req_size = 2'd0; req_wdata = 64'h05;
        check("R7", busy, 1'b1, "busy during 4-byte access");
        while (busy) @(negedge clk);
        req_valid = 1'b0;
        access(1'b0, 16'h03C4, 2'd0, 64'h0, rd, miss, got);
        check("R8", rd, 64'h07, "index unchanged by dropped request");

        // R10 re-entry pulses again
        access(1'b1, 16'h03C5, 2'd0, 64'h00, rd, miss, got);
        check("R10", {std_mode, cache_start}, 72'h3, "second entry pulse");

        // R11 reset clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11", {8'h0, seq_regs}, 72'h0, "seq_regs after mid reset");
        check("R11", gfx_regs, 72'h0, "gfx_regs after mid reset");
        check("R11", {std_mode, cache_en}, 72'h0, "mode after mid reset");
        access(1'b0, 16'h03CE, 2'd1, 64'h0, rd, miss, got);
        check("R11", {miss, rd}, 72'h0, "gfx index and reg0 after reset");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R7 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule